// File: doc/BRIEF.md
# Packed Lane Sum Reduction Unit

This unit collapses a packed 128-bit operand into one scalar by adding all of its lanes together. The lane width and the active vector width are both chosen per request, so one instance covers byte, halfword and word lanes over a half-width (64-bit) or full-width (128-bit) operand. The sum wraps at the lane width, and the result is zero-extended into a 128-bit destination word.

A request is presented with `in_valid` together with the operand and its configuration. One clock later `out_valid` pulses and the destination word and the configuration-error flag are valid. They stay unchanged until the next request is accepted. Configurations that would reduce fewer than four lanes, and the unused lane code, are rejected: the error flag is raised and the destination is all zeros. The unit has no condition-flag outputs.

Top module: `lane_sum_unit`

## Requirements
- R1: With `lane_code`=00 the lanes are 8 bits wide and the result is the sum of all active bytes (16 when `wide_sel`=1).
- R2: With `lane_code`=01 the lanes are 16 bits wide and the result is the sum of all active halfwords.
- R3: With `lane_code`=10 and `wide_sel`=1 the lanes are 32 bits wide and the result is the sum of the four words.
- R4: With `wide_sel`=0 only `src_vec[63:0]` is reduced, and bits 127:64 have no effect on the result.
- R5: The sum is taken modulo 2 to the power of the lane width, so any carry out of the lane is discarded (for example, sixteen bytes of 0xFF give 0xF0).
- R6: `dst_vec` holds the sum in its lowest lane-width bits, and every bit above that, up to bit 127, is zero.
- R7: `lane_code`=11 with either `wide_sel`, and `lane_code`=10 with `wide_sel`=0, set `bad_cfg`=1 and give `dst_vec`=0. Legal configurations give `bad_cfg`=0.
- R8: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and low otherwise.
- R9: While `in_valid` is low, `dst_vec` and `bad_cfg` keep their values whatever the other inputs do.
- R10: While `rst_n` is low, `out_valid`, `bad_cfg` and `dst_vec` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Request strobe; the operand and configuration are sampled while it is high |
| src_vec | input | 128 | Packed source operand |
| lane_code | input | 2 | Lane width: 00 = 8 bits, 01 = 16 bits, 10 = 32 bits, 11 = illegal |
| wide_sel | input | 1 | 1 = reduce all 128 bits, 0 = reduce the low 64 bits only |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| dst_vec | output | 128 | Zero-extended scalar sum |
| bad_cfg | output | 1 | Illegal configuration flag for the current result |

## Verification
A wrong node in the adder tree shows in `dst_vec` on the `out_valid` pulse that follows the request, but only when the operand puts nonzero data into that node's lanes. For this reason the vectors include distinct values per lane, all-ones lanes and dirty upper halves. A wrong lane-width or error decode appears in the same cycle, either as nonzero bits above the lane or as a wrong `bad_cfg`. A broken clock enable shows one cycle later, when `dst_vec` changes during an idle cycle.

// File: rtl/lane_sum_pkg.sv
package lane_sum_pkg;
  localparam int VEC_W     = 128;
  localparam int MIN_LANE  = 8;
  localparam int N_WIDTHS  = 3;
  localparam int MAX_LANE  = MIN_LANE << (N_WIDTHS - 1);

  typedef enum logic [1:0] {
    LANE_B8  = 2'b00,
    LANE_B16 = 2'b01,
    LANE_B32 = 2'b10,
    LANE_BAD = 2'b11
  } lane_code_e;
endpackage

// File: rtl/lane_sum_decode.sv
module lane_sum_decode
  import lane_sum_pkg::*;
(
  input  logic [1:0]          lane_code,
  input  logic                wide_sel,
  output logic                cfg_ok,
  output logic [N_WIDTHS-1:0] width_sel
);
  always_comb begin
    width_sel = '0;
    unique case (lane_code_e'(lane_code))
      LANE_B8:  width_sel[0] = 1'b1;
      LANE_B16: width_sel[1] = 1'b1;
      LANE_B32: width_sel[2] = wide_sel;
      default:  width_sel = '0;
    endcase
    cfg_ok = |width_sel;
  end

  // R7: at most one width path is ever selected
  always_comb begin
    p_sel_onehot_r7: assert ($onehot0(width_sel))
      else $error("width select not one-hot");
  end
endmodule

// File: rtl/lane_sum_tree.sv
module lane_sum_tree #(
  parameter int LANE_W  = 8,
  parameter int N_LANES = 16
) (
  input  logic [LANE_W*N_LANES-1:0] lanes_in,
  output logic [LANE_W-1:0]         sum_out
);
  localparam int DEPTH = $clog2(N_LANES);

  for (genvar l = 0; l <= DEPTH; l++) begin : g_lvl
    localparam int CNT = N_LANES >> l;
    logic [LANE_W*CNT-1:0] v;
    if (l == 0) begin : g_leaf
      assign v = lanes_in;
    end else begin : g_add
      for (genvar k = 0; k < CNT; k++) begin : g_pair
        assign v[k*LANE_W +: LANE_W] =
          g_lvl[l-1].v[(2*k)*LANE_W +: LANE_W] +
          g_lvl[l-1].v[(2*k+1)*LANE_W +: LANE_W];
      end
    end
  end

  assign sum_out = g_lvl[DEPTH].v;
endmodule

// File: rtl/lane_sum_unit.sv
module lane_sum_unit
  import lane_sum_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [1:0]       lane_code,
  input  logic             wide_sel,
  output logic             out_valid,
  output logic [VEC_W-1:0] dst_vec,
  output logic             bad_cfg
);
  localparam int HALF_W = VEC_W / 2;

  logic                cfg_ok;
  logic [N_WIDTHS-1:0] width_sel;
  logic [VEC_W-1:0]    src_act;
  logic [VEC_W-1:0]    sum_ext [N_WIDTHS];
  logic [VEC_W-1:0]    dst_nxt;
  logic                bad_nxt;
  logic                vld_q;
  logic [VEC_W-1:0]    dst_q;
  logic                bad_q;

  lane_sum_decode u_decode (
    .lane_code (lane_code),
    .wide_sel  (wide_sel),
    .cfg_ok    (cfg_ok),
    .width_sel (width_sel)
  );

  // Narrow mode: zero lanes contribute nothing to the sum
  assign src_act = wide_sel ? src_vec : {{HALF_W{1'b0}}, src_vec[HALF_W-1:0]};

  for (genvar g = 0; g < N_WIDTHS; g++) begin : g_width
    localparam int LW = MIN_LANE << g;
    logic [LW-1:0] s;
    lane_sum_tree #(.LANE_W(LW), .N_LANES(VEC_W / LW)) u_tree (
      .lanes_in (src_act),
      .sum_out  (s)
    );
    assign sum_ext[g] = {{(VEC_W-LW){1'b0}}, s};
  end

  always_comb begin
    dst_nxt = '0;
    for (int g = 0; g < N_WIDTHS; g++) begin
      if (width_sel[g]) dst_nxt = sum_ext[g];
    end
    bad_nxt = ~cfg_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dst_q <= '0;
      bad_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        dst_q <= dst_nxt;
        bad_q <= bad_nxt;
      end
    end
  end

  assign out_valid = vld_q;
  assign dst_vec   = dst_q;
  assign bad_cfg   = bad_q;

  // R6: nothing above the widest lane ever carries data
  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dst_vec[VEC_W-1:MAX_LANE] == '0);
  // R7: a rejected configuration yields an all-zero destination
  p_bad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cfg |-> dst_vec == '0);
  // R8: a request is answered in exactly the next cycle
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R9: results hold during idle cycles
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(dst_vec) && $stable(bad_cfg)));
endmodule

// File: tb/test_lane_sum_unit.sv
`timescale 1ns/1ps
module test_lane_sum_unit;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] src_vec;
  logic [1:0]   lane_code;
  logic         wide_sel;
  logic         out_valid;
  logic [127:0] dst_vec;
  logic         bad_cfg;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  lane_sum_unit i_lane_sum_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
    .lane_code(lane_code), .wide_sel(wide_sel), .out_valid(out_valid),
    .dst_vec(dst_vec), .bad_cfg(bad_cfg)
  );

  // {lane_code, wide_sel, src_vec}
  localparam int NV = 12;
  localparam logic [130:0] VECS [NV] = '{
    {2'b00, 1'b1, {16{8'hFF}}},
    {2'b00, 1'b1, 128'h100F0E0D0C0B0A090807060504030201},
    {2'b00, 1'b0, 128'hDEADBEEFCAFEF00D0807060504030201},
    {2'b00, 1'b0, {16{8'hFF}}},
    {2'b01, 1'b1, {8{16'hFFFF}}},
    {2'b01, 1'b1, 128'h00080007000600050004000300020001},
    {2'b01, 1'b0, 128'hFFFFFFFFFFFFFFFF1000200030004000},
    {2'b10, 1'b1, {4{32'h80000000}}},
    {2'b10, 1'b1, 128'h00000004000000030000000200000001},
    {2'b10, 1'b0, 128'h00000004000000030000000200000001},
    {2'b11, 1'b1, {16{8'h11}}},
    {2'b11, 1'b0, {16{8'h22}}}
  };

  function automatic logic [128:0] ref_out(input logic [1:0] c, input logic w,
                                           input logic [127:0] s);
    int lw, n;
    logic [31:0] acc;
    logic [31:0] mask;
    if (c == 2'b11 || (c == 2'b10 && !w)) return {1'b1, 128'd0};
    lw   = 8 << c;
    n    = (w ? 128 : 64) / lw;
    mask = (lw == 32) ? 32'hFFFFFFFF : ((32'd1 << lw) - 1);
    acc  = 0;
    for (int i = 0; i < n; i++) acc = (acc + ((s >> (i*lw)) & 128'(mask))) & mask;
    return {1'b0, 96'd0, acc};
  endfunction

  function automatic string tag_of(input logic [1:0] c, input logic w);
    if (c == 2'b11 || (c == 2'b10 && !w)) return "R7";
    if (!w) return "R4";
    if (c == 2'b00) return "R1";
    if (c == 2'b01) return "R2";
    return "R3";
  endfunction

  task automatic chk(input string tag, input logic [128:0] act, input logic [128:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Request at a falling edge, result checked at the next falling edge
  task automatic issue(input logic [1:0] c, input logic w, input logic [127:0] s,
                       input string tag);
    logic [128:0] e;
    e = ref_out(c, w, s);
    lane_code = c; wide_sel = w; src_vec = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " result"}, {bad_cfg, dst_vec}, e);
    chk("R8 valid pulse", {128'd0, out_valid}, 129'd1);
    chk("R6 upper zero", {1'b0, 96'd0, dst_vec[127:32]} == 0 ? 129'd0 : 129'd1, 129'd0);
    src_vec = ~s; lane_code = ~c; wide_sel = ~w;
    @(negedge clk);
    chk("R8 valid drop", {128'd0, out_valid}, 129'd0);
    chk("R9 hold", {bad_cfg, dst_vec}, e);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; src_vec = '0; lane_code = '0; wide_sel = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset state", {bad_cfg, dst_vec}, 129'd0);
    chk("R10 reset valid", {128'd0, out_valid}, 129'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++)
      issue(VECS[v][130:129], VECS[v][128], VECS[v][127:0],
            tag_of(VECS[v][130:129], VECS[v][128]));

    // R5: explicit wraparound values
    issue(2'b00, 1'b1, {16{8'hFF}}, "R5");
    chk("R5 byte wrap", {bad_cfg, dst_vec}, {1'b0, 120'd0, 8'hF0});
    issue(2'b10, 1'b1, {4{32'hFFFFFFFF}}, "R5");
    chk("R5 word wrap", {bad_cfg, dst_vec}, {1'b0, 96'd0, 32'hFFFFFFFC});
    // R4: upper half change has no effect in narrow mode
    issue(2'b01, 1'b0, 128'h0000000000000000_0001000100010001, "R4");
    chk("R4 clean upper", {bad_cfg, dst_vec}, {1'b0, 112'd0, 16'd4});
    issue(2'b01, 1'b0, 128'hFFFF0000FFFF1234_0001000100010001, "R4");
    chk("R4 dirty upper", {bad_cfg, dst_vec}, {1'b0, 112'd0, 16'd4});
    // R7 then legal: flag clears
    issue(2'b11, 1'b1, {16{8'h01}}, "R7");
    issue(2'b00, 1'b1, {16{8'h01}}, "R1");
    chk("R7 flag cleared", {128'd0, bad_cfg}, 129'd0);

    // R10: reset after activity clears state
    issue(2'b00, 1'b1, {16{8'h03}}, "R1");
    rst_n = 1'b0;
    #1;
    chk("R10 mid reset data", {bad_cfg, dst_vec}, 129'd0);
    chk("R10 mid reset valid", {128'd0, out_valid}, 129'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20000 * 5.0);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule